// File: doc/BRIEF.md
# Posted Write Buffer Bus Bridge

The bridge sits behind one internal bus master and steers each request to one of three places. These are a slow external memory bus, a fast on-chip peripheral bus, or a small bank of the bridge's own configuration registers. The most significant address bit selects the external space. Below that, the next bit separates peripheral space from configuration space. A write to external space is posted into a single-entry buffer. The master is released in the same cycle, and the external cycle then runs for a fixed number of clock cycles. Peripheral accesses issued during that time complete at once and overtake the external write.

Reads always hold the master until their data is present. A read to external space first lets the buffered write drain, then runs its own external cycle. A read that follows a write to the same address therefore sees the new data. Configuration writes and second external writes wait, with ready low, while the buffer is occupied.

There are two reset flavours. Power-on reset (`por_n`, asynchronous, active low) immediately quiets every external strobe and output enable and restores the configuration registers. Manual reset (`mrst`) keeps the registers, lets a running external cycle end, then refuses new requests. While `mrst` is high, the external bus-request input cannot win a grant. The `hold` input models sleep or standby. It only blocks new requests.

Top module: `pwb_bridge`

## Requirements
- R1: An external write (`m_addr[AW-1]`=0) presented while the buffer is empty, no read is in flight and no grant is held is accepted in that cycle (`m_ready`=1). From the next cycle, `ext_cs_n` and `ext_we_n` stay low and `ext_dq_oe` stays high for exactly EXT_CYC cycles, driving that address and data.
- R2: A peripheral access (`m_addr[AW-1:AW-2]`=2'b10) is accepted in the cycle presented, with `p_sel` high, even while the buffered external write is still running. Its read data is `p_rdata` in that cycle.
- R3: An external write presented while the buffer holds a pending write keeps `m_ready` low until the pending cycle has ended. The new write is then accepted and not lost.
- R4: An external read keeps `m_ready` low until its own external cycle reaches its last wait cycle, and only starts after any buffered write has completed. On an empty buffer it waits EXT_CYC cycles. A read of an address just written returns the written data.
- R5: A configuration write (`m_addr[AW-1:AW-2]`=2'b11, register index in `m_addr[CIW-1:0]`) presented while the buffer is occupied is stalled with `m_ready` low. It takes effect once the buffer drains. Configuration reads complete in the cycle presented.
- R6: While `por_n` is low, `ext_cs_n`, `ext_we_n` and `ext_rd_n` are high and `ext_dq_oe`, `ext_ctl_oe` and `bgnt` are low, whatever cycle was running. Configuration register i returns to CFG_RST+i.
- R7: While `mrst` is high, a running external cycle runs to completion and its write lands. No new request is accepted (`m_ready` and `p_sel` low). Configuration registers keep their values.
- R8: `breq` is ignored while `mrst` is high (`bgnt` stays low). Otherwise `bgnt` rises one cycle after `breq` once the external bus is idle. While `bgnt` is high, `ext_ctl_oe` is low and external requests stall.
- R9: While `hold` is high, no new request is accepted. A buffered write still completes and configuration contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst | input | 1 | Manual reset, active high |
| hold | input | 1 | Sleep/standby hold-off of new requests |
| m_valid | input | 1 | Master request valid; request held stable until m_ready |
| m_ready | output | 1 | Request completes in this cycle |
| m_write | input | 1 | 1 = write, 0 = read |
| m_addr | input | AW | Request address |
| m_wdata | input | DW | Write data |
| m_rdata | output | DW | Read data, valid when m_ready on a read |
| ext_cs_n | output | 1 | External chip select, active low |
| ext_we_n | output | 1 | External write strobe, active low |
| ext_rd_n | output | 1 | External read strobe, active low |
| ext_addr | output | AW | External address |
| ext_wdata | output | DW | External write data |
| ext_rdata | input | DW | External read data |
| ext_dq_oe | output | 1 | External data bus drive enable |
| ext_ctl_oe | output | 1 | External address/control drive enable |
| p_sel | output | 1 | Peripheral select, one cycle per access |
| p_write | output | 1 | Peripheral write |
| p_addr | output | AW | Peripheral address |
| p_wdata | output | DW | Peripheral write data |
| p_rdata | input | DW | Peripheral read data |
| breq | input | 1 | External bus request |
| bgnt | output | 1 | External bus grant |

## Verification
The bench builds the bridge with AW=16, DW=16, NCFG=4 and EXT_CYC=4. With four wait cycles, two peripheral accesses fit inside one posted write, and the stall counts separate cleanly: EXT_CYC for a write behind a write, and 2*EXT_CYC for a read behind a write. The small external window also leaves room to raise manual reset, hold or power-on reset in the middle of a running cycle and watch the strobes at the pins.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    RGN_EXT = 2'd0,
    RGN_PER = 2'd1,
    RGN_CFG = 2'd2
  } region_e;
endpackage

// File: rtl/pwb_decode.sv
module pwb_decode #(
  parameter int AW = 16
) (
  input  logic [AW-1:0]    addr,
  output pwb_pkg::region_e rgn
);
  import pwb_pkg::*;

  always_comb begin
    if (!addr[AW-1])      rgn = RGN_EXT;
    else if (addr[AW-2])  rgn = RGN_CFG;
    else                  rgn = RGN_PER;
  end
endmodule

// File: rtl/pwb_ext_engine.sv
module pwb_ext_engine #(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int EXT_CYC = 3
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          start,
  input  logic          start_we,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_data,
  output logic          busy,
  output logic          done,
  output logic          cur_we,
  output logic [AW-1:0] cur_addr,
  output logic [DW-1:0] cur_data
);
  localparam int CW = $clog2(EXT_CYC + 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == CW'(EXT_CYC - 1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      cur_we   <= 1'b0;
      cur_addr <= '0;
      cur_data <= '0;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      else      cnt  <= cnt + 1'b1;
    end else if (start) begin
      busy     <= 1'b1;
      cnt      <= '0;
      cur_we   <= start_we;
      cur_addr <= start_addr;
      cur_data <= start_data;
    end
  end

  a_r1_start_idle: assert property (@(posedge clk) disable iff (!por_n)
    start |-> !busy);
  a_r1_done_frees: assert property (@(posedge clk) disable iff (!por_n)
    done |=> !busy);
  a_r1_entry_stable: assert property (@(posedge clk) disable iff (!por_n)
    (busy && !done) |=> ($stable(cur_addr) && $stable(cur_data) && $stable(cur_we)));
endmodule

// File: rtl/pwb_cfg_regs.sv
module pwb_cfg_regs #(
  parameter int          DW      = 16,
  parameter int          NCFG    = 4,
  parameter logic [DW-1:0] CFG_RST = '0
) (
  input  logic                    clk,
  input  logic                    por_n,
  input  logic                    we,
  input  logic [$clog2(NCFG)-1:0] idx,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata
);
  logic [DW-1:0] regs [NCFG];

  for (genvar i = 0; i < NCFG; i++) begin : g_reg
    localparam logic [DW-1:0] DFLT = CFG_RST + DW'(i);
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                  regs[i] <= DFLT;
      else if (we && (int'(idx) == i)) regs[i] <= wdata;
    end
  end

  assign rdata = regs[idx];
endmodule

// File: rtl/pwb_bridge.sv
module pwb_bridge #(
  parameter int            AW      = 16,
  parameter int            DW      = 16,
  parameter int            EXT_CYC = 3,
  parameter int            NCFG    = 4,
  parameter logic [DW-1:0] CFG_RST = 16'h0100
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          mrst,
  input  logic          hold,
  input  logic          m_valid,
  output logic          m_ready,
  input  logic          m_write,
  input  logic [AW-1:0] m_addr,
  input  logic [DW-1:0] m_wdata,
  output logic [DW-1:0] m_rdata,
  output logic          ext_cs_n,
  output logic          ext_we_n,
  output logic          ext_rd_n,
  output logic [AW-1:0] ext_addr,
  output logic [DW-1:0] ext_wdata,
  input  logic [DW-1:0] ext_rdata,
  output logic          ext_dq_oe,
  output logic          ext_ctl_oe,
  output logic          p_sel,
  output logic          p_write,
  output logic [AW-1:0] p_addr,
  output logic [DW-1:0] p_wdata,
  input  logic [DW-1:0] p_rdata,
  input  logic          breq,
  output logic          bgnt
);
  import pwb_pkg::*;

  localparam int CIW = $clog2(NCFG);

  region_e       rgn;
  logic          eng_start, eng_busy, eng_done, eng_we;
  logic          cfg_we, rd_launch, rd_inflight, bgnt_q;
  logic          accept_ok, ext_free;
  logic [DW-1:0] cfg_rdata;

  pwb_decode #(.AW(AW)) u_dec (.addr(m_addr), .rgn(rgn));

  pwb_ext_engine #(.AW(AW), .DW(DW), .EXT_CYC(EXT_CYC)) u_eng (
    .clk(clk), .por_n(por_n), .start(eng_start), .start_we(m_write),
    .start_addr(m_addr), .start_data(m_wdata), .busy(eng_busy),
    .done(eng_done), .cur_we(eng_we), .cur_addr(ext_addr), .cur_data(ext_wdata)
  );

  pwb_cfg_regs #(.DW(DW), .NCFG(NCFG), .CFG_RST(CFG_RST)) u_cfg (
    .clk(clk), .por_n(por_n), .we(cfg_we), .idx(m_addr[CIW-1:0]),
    .wdata(m_wdata), .rdata(cfg_rdata)
  );

  assign accept_ok = !mrst && !hold;
  assign ext_free  = !eng_busy && !bgnt_q && !rd_inflight;

  always_comb begin
    m_ready   = 1'b0;
    m_rdata   = '0;
    p_sel     = 1'b0;
    eng_start = 1'b0;
    cfg_we    = 1'b0;
    rd_launch = 1'b0;
    if (rd_inflight) begin
      if (eng_done) begin
        m_ready = 1'b1;
        m_rdata = ext_rdata;
      end
    end else if (m_valid && accept_ok) begin
      unique case (rgn)
        RGN_EXT: begin
          if (ext_free) begin
            eng_start = 1'b1;
            if (m_write) m_ready   = 1'b1;
            else         rd_launch = 1'b1;
          end
        end
        RGN_PER: begin
          p_sel   = 1'b1;
          m_ready = 1'b1;
          if (!m_write) m_rdata = p_rdata;
        end
        default: begin
          if (m_write) begin
            if (!eng_busy) begin
              cfg_we  = 1'b1;
              m_ready = 1'b1;
            end
          end else begin
            m_ready = 1'b1;
            m_rdata = cfg_rdata;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rd_inflight <= 1'b0;
      bgnt_q      <= 1'b0;
    end else begin
      if (rd_launch)                    rd_inflight <= 1'b1;
      else if (rd_inflight && eng_done) rd_inflight <= 1'b0;
      bgnt_q <= breq && !mrst &&
                (bgnt_q || (!eng_busy && !rd_inflight && !eng_start));
    end
  end

  assign bgnt       = bgnt_q;
  assign ext_ctl_oe = por_n && !bgnt_q;
  assign ext_cs_n   = !(por_n && eng_busy);
  assign ext_we_n   = !(por_n && eng_busy && eng_we);
  assign ext_rd_n   = !(por_n && eng_busy && !eng_we);
  assign ext_dq_oe  = por_n && !bgnt_q && eng_busy && eng_we;
  assign p_write    = m_write;
  assign p_addr     = m_addr;
  assign p_wdata    = m_wdata;

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!por_n)
    (m_valid && m_write && rgn == RGN_EXT && eng_busy) |-> !m_ready);
  a_r4_read_waits: assert property (@(posedge clk) disable iff (!por_n)
    (rd_inflight && !eng_done) |-> !m_ready);
  a_r5_cfg_stall: assert property (@(posedge clk) disable iff (!por_n)
    (m_valid && m_write && rgn == RGN_CFG && eng_busy) |-> !m_ready);
  a_r7_mrst_blocks: assert property (@(posedge clk) disable iff (!por_n)
    (mrst && !rd_inflight) |-> (!m_ready && !p_sel && !eng_start));
  a_r8_no_grant_in_mrst: assert property (@(posedge clk) disable iff (!por_n)
    mrst |=> !bgnt);
  a_r8_grant_bus_quiet: assert property (@(posedge clk) disable iff (!por_n)
    bgnt |-> (ext_cs_n && !ext_ctl_oe));
  a_r9_hold_blocks: assert property (@(posedge clk) disable iff (!por_n)
    (hold && !rd_inflight) |-> !m_ready);
endmodule

// File: tb/pwb_bridge_tb_top.sv
module pwb_bridge_tb_top;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int EXT_CYC = 4;
  localparam int NCFG = 4;
  localparam logic [DW-1:0] CFG_RST = 16'h0100;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic por_n, mrst, hold, m_valid, m_ready, m_write, breq, bgnt;
  logic [AW-1:0] m_addr, ext_addr, p_addr;
  logic [DW-1:0] m_wdata, m_rdata, ext_wdata, ext_rdata, p_wdata, p_rdata;
  logic ext_cs_n, ext_we_n, ext_rd_n, ext_dq_oe, ext_ctl_oe, p_sel, p_write;

  pwb_bridge #(.AW(AW), .DW(DW), .EXT_CYC(EXT_CYC), .NCFG(NCFG), .CFG_RST(CFG_RST)) dut_i (
    .clk(clk), .por_n(por_n), .mrst(mrst), .hold(hold),
    .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_rdata(m_rdata),
    .ext_cs_n(ext_cs_n), .ext_we_n(ext_we_n), .ext_rd_n(ext_rd_n),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .ext_dq_oe(ext_dq_oe), .ext_ctl_oe(ext_ctl_oe),
    .p_sel(p_sel), .p_write(p_write), .p_addr(p_addr), .p_wdata(p_wdata),
    .p_rdata(p_rdata), .breq(breq), .bgnt(bgnt)
  );

  // external memory and peripheral models
  logic [DW-1:0] mem [256];
  logic [DW-1:0] per_last;
  initial for (int i = 0; i < 256; i++) mem[i] = '0;
  always @(posedge clk) if (!ext_cs_n && !ext_we_n && ext_dq_oe) mem[ext_addr[7:0]] <= ext_wdata;
  assign ext_rdata = mem[ext_addr[7:0]];
  assign p_rdata   = p_addr ^ 16'h5A5A;
  always @(posedge clk) if (p_sel && p_write) per_last <= p_wdata;

  int n_vec = 0;
  int n_bad = 0;
  logic [DW-1:0] exp_q [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data on every read handshake
  always @(negedge clk) begin
    #5;
    if (por_n === 1'b1 && m_valid && m_ready && !m_write) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected read", 32'(m_rdata), 32'hFFFF_FFFF);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(m_rdata == e, "R2/R4/R5 read data", 32'(m_rdata), 32'(e));
      end
    end
  end

  int  waited;
  logic ovl;

  task automatic acc(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    m_valid = 1'b1; m_write = w; m_addr = a; m_wdata = d;
    waited = 0;
    forever begin
      #5;
      if (m_ready) begin
        ovl = !ext_cs_n;
        @(posedge clk);
        break;
      end
      @(posedge clk);
      waited++;
      if (waited > 300) begin
        chk(1'b0, "handshake timeout", 32'(waited), 0);
        break;
      end
      @(negedge clk);
    end
    #1 m_valid = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e);
    exp_q.push_back(e);
    acc(1'b0, a, '0);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 50 && !(ext_cs_n === 1'b1); i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // stalled-request observation: drive and check ready stays low for n cycles
  task automatic expect_stall(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      #5;
      chk(m_ready == 1'b0 && p_sel == 1'b0, tag, 32'(m_ready), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 200000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    por_n = 1'b0; mrst = 1'b0; hold = 1'b0; breq = 1'b0;
    m_valid = 1'b0; m_write = 1'b0; m_addr = '0; m_wdata = '0;
    repeat (3) @(negedge clk);
    // R6 reset state
    chk(ext_cs_n && ext_we_n && ext_rd_n && !ext_dq_oe && !ext_ctl_oe && !bgnt,
        "R6 outputs in reset", {ext_cs_n, ext_we_n, ext_rd_n, ext_dq_oe, ext_ctl_oe, bgnt}, 6'b111000);
    por_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 posted write, R2 overtaking peripheral accesses
    acc(1'b1, 16'h0010, 16'h1111);
    chk(waited == 0, "R1 posted write accepted at once", waited, 0);
    acc(1'b1, 16'h8004, 16'hBEEF);
    chk(waited == 0 && ovl, "R2 peripheral write overtakes", {waited[7:0], 7'd0, ovl}, 1);
    rd(16'h8008, 16'h8008 ^ 16'h5A5A);
    chk(waited == 0 && ovl, "R2 peripheral read overtakes", {waited[7:0], 7'd0, ovl}, 1);
    chk(per_last == 16'hBEEF, "R2 peripheral write data", per_last, 16'hBEEF);
    wait_idle();
    chk(mem[8'h10] == 16'h1111, "R1 external write landed", mem[8'h10], 16'h1111);
    rd(16'h0010, 16'h1111);
    chk(waited == EXT_CYC, "R4 read on empty buffer latency", waited, EXT_CYC);

    // R3 write behind write, R4 read behind write
    acc(1'b1, 16'h0020, 16'hA0A0);
    acc(1'b1, 16'h0021, 16'hB1B1);
    chk(waited == EXT_CYC, "R3 second write stalls", waited, EXT_CYC);
    rd(16'h0021, 16'hB1B1);
    chk(waited == 2 * EXT_CYC, "R4 read drains buffer first", waited, 2 * EXT_CYC);
    rd(16'h0020, 16'hA0A0);

    // R5 config default, stalled config write
    rd(16'hC002, CFG_RST + 16'd2);
    chk(waited == 0, "R5 config read immediate", waited, 0);
    acc(1'b1, 16'h0030, 16'h3333);
    acc(1'b1, 16'hC001, 16'hABCD);
    chk(waited == EXT_CYC, "R5 config write stalled by buffer", waited, EXT_CYC);
    rd(16'hC001, 16'hABCD);

    // R7 manual reset during an external write
    acc(1'b1, 16'h0040, 16'h4444);
    @(negedge clk);
    mrst = 1'b1; breq = 1'b1;
    chk(ext_cs_n == 1'b0, "R7 running cycle continues", ext_cs_n, 0);
    repeat (6) @(negedge clk);
    chk(mem[8'h40] == 16'h4444, "R7 cycle completed under manual reset", mem[8'h40], 16'h4444);
    chk(bgnt == 1'b0, "R8 breq ignored in manual reset", bgnt, 0);
    exp_q.push_back(16'h800C ^ 16'h5A5A);
    m_valid = 1'b1; m_write = 1'b0; m_addr = 16'h800C;
    expect_stall(4, "R7 request refused in manual reset");
    chk(bgnt == 1'b0, "R8 still no grant", bgnt, 0);
    mrst = 1'b0;
    #5 chk(m_ready == 1'b1, "R7 accepted after release", m_ready, 1);
    @(posedge clk); #1 m_valid = 1'b0;
    @(negedge clk);
    chk(bgnt == 1'b1 && ext_ctl_oe == 1'b0, "R8 grant after release", {bgnt, ext_ctl_oe}, 2'b10);
    m_valid = 1'b1; m_write = 1'b1; m_addr = 16'h0041; m_wdata = 16'h4141;
    for (int i = 0; i < 3; i++) begin
      #5 chk(m_ready == 1'b0, "R8 external write stalls under grant", m_ready, 0);
      @(negedge clk);
    end
    breq = 1'b0;
    @(negedge clk);
    #5 chk(m_ready == 1'b1, "R8 write proceeds after grant drop", m_ready, 1);
    @(posedge clk); #1 m_valid = 1'b0;
    wait_idle();
    chk(mem[8'h41] == 16'h4141, "R8 stalled write landed", mem[8'h41], 16'h4141);
    rd(16'hC001, 16'hABCD);

    // R9 hold
    acc(1'b1, 16'h0050, 16'h5555);
    @(negedge clk);
    hold = 1'b1;
    exp_q.push_back(16'hABCD);
    m_valid = 1'b1; m_write = 1'b0; m_addr = 16'hC001;
    expect_stall(6, "R9 request refused in hold");
    chk(mem[8'h50] == 16'h5555, "R9 buffered write completed in hold", mem[8'h50], 16'h5555);
    hold = 1'b0;
    #5 chk(m_ready == 1'b1, "R9 accepted after hold", m_ready, 1);
    @(posedge clk); #1 m_valid = 1'b0;

    // R6 power-on reset mid-cycle
    acc(1'b1, 16'h0060, 16'h6666);
    @(negedge clk);
    chk(ext_cs_n == 1'b0, "R6 cycle running before reset", ext_cs_n, 0);
    por_n = 1'b0;
    #1 chk(ext_cs_n && ext_we_n && !ext_dq_oe && !ext_ctl_oe, "R6 immediate quiet",
           {ext_cs_n, ext_we_n, ext_dq_oe, ext_ctl_oe}, 4'b1100);
    @(negedge clk);
    por_n = 1'b1;
    rd(16'hC001, CFG_RST + 16'd1);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all reads returned", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule